// File: doc/BRIEF.md
# Refresh Interval Timer

This block paces DRAM refresh for a memory controller. An 8-bit up-counter advances on a strobe from a selectable clock prescaler. It is compared every cycle with an 8-bit interval constant. When the two are equal, three things happen: the counter returns to zero, a sticky match flag is set, and, if refresh is enabled, a refresh request goes to the refresh sequencer. The sequencer answers with a one-cycle done pulse, and that pulse drops the request.

Software reaches the block over a small synchronous register bus. It chooses the prescale and the enable bit, loads the interval constant, reads or overwrites the counter at any time, and clears the match flag through a read-then-write-zero protocol. The request is not queued. If further matches arrive while a request is pending, they merge into that one request, and a single done pulse clears it.

Top module: `rfsh_interval_timer`

## Requirements
- R1: After reset the counter, the constant, the select field and the enable bit are 0, `refresh_req` is low and `bus_rdata` is 0.
- R2: The select field CSR[2:0] stops the counter when it is 0. For values 1 to 7 it divides the system clock by 4, 16, 64, 256, 1024, 2048 and 4096. The counter gains exactly 1 per prescaler strobe, so with constant C matches recur every C times the divisor cycles.
- R3: A bus write to the counter loads the written low byte and wins over both counting and the match clear in that cycle.
- R4: In any cycle where the counter equals the constant, the counter is 0 on the next cycle and the match flag CSR[7] is set.
- R5: If the counter holds a value above the constant, it counts through 255, wraps to 0 and goes on to match.
- R6: Bits 15..8 of the counter and constant read as 0, and writes to those bits have no effect.
- R7: The match flag is cleared only by a CSR write with bit 7 at 0 that follows a CSR read which returned the flag as 1. A match in the same cycle keeps the flag set.
- R8: With the enable bit CSR[3] at 1, a match raises `refresh_req` on the next cycle. With it at 0, a match raises no request but still sets the flag.
- R9: `refresh_req` stays high until a `refresh_done` pulse, which drops it on the next cycle unless a new enabled match occurs in the same cycle.
- R10: Several matches while a request is pending leave one request, and one done pulse clears it.
- R11: The registers sit at word offsets 0 (CSR), 1 (counter) and 2 (constant); offset 3 reads 0. Read data appears the cycle after `bus_rd` and is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register word offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| refresh_done | input | 1 | Refresh serviced acknowledge from sequencer |
| refresh_req | output | 1 | Pending refresh request |

## Verification
A table of register writes and read-backs is walked first, with the counter stopped. This separates storage of the low byte from masking of the upper byte, and it tells the unused offset apart from the real registers. Match periods are then timed at two prescale settings with different constants. That distinguishes a correct divisor and correct compare-and-clear from off-by-one counting. Directed cases cover four more things: a counter write landing in a match cycle, the flag clear with and without the preceding read and against a simultaneous match, a count that starts above the constant and must wrap, and piled-up matches drained by a single done pulse with refresh disabled.

// File: rtl/rft_pkg.sv
package rft_pkg;
  localparam int CNT_W  = 8;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;
  localparam int SEL_W  = 3;
  localparam int PRE_W  = 12;

  localparam logic [ADDR_W-1:0] OFS_CSR = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_CNT = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_TC  = 2'd2;

  localparam int CSR_EN_BIT   = 3;
  localparam int CSR_FLAG_BIT = 7;

  // Divider mask (divisor - 1); a strobe fires when the masked prescaler bits are all ones
  function automatic logic [PRE_W-1:0] pre_mask(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    pre_mask = PRE_W'(4 - 1);
      3'd2:    pre_mask = PRE_W'(16 - 1);
      3'd3:    pre_mask = PRE_W'(64 - 1);
      3'd4:    pre_mask = PRE_W'(256 - 1);
      3'd5:    pre_mask = PRE_W'(1024 - 1);
      3'd6:    pre_mask = PRE_W'(2048 - 1);
      3'd7:    pre_mask = PRE_W'(4096 - 1);
      default: pre_mask = '0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] v);
    cnt_step = v + CNT_W'(1);
  endfunction
endpackage

// File: rtl/rft_prescaler.sv
module rft_prescaler
  import rft_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PW'(1);
  end

  assign mask = PW'(pre_mask(SEL_W'(sel)));
  assign tick = (sel != '0) && ((pre_q & mask) == mask);

  // R2: a strobe is a single-cycle pulse for every divisor
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rft_counter.sv
module rft_counter
  import rft_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] tc_val,
  output logic [W-1:0] cnt,
  output logic         match
);
  logic [W-1:0] cnt_d;

  assign match = (cnt == tc_val);

  always_comb begin
    if (wr_cnt)     cnt_d = wr_val;
    else if (match) cnt_d = '0;
    else if (tick)  cnt_d = W'(cnt_step(CNT_W'(cnt)));
    else            cnt_d = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R3: a bus write lands regardless of tick or match
  a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(wr_val));
  // R4: a match without a write returns the counter to zero
  a_r4_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !wr_cnt) |=> cnt == '0);
  // R5: counting past the top wraps to zero
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {W{1'b1}} && tick && !match && !wr_cnt) |=> cnt == '0);
endmodule

// File: rtl/rft_req_ctrl.sv
module rft_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic en,
  input  logic done,
  input  logic csr_rd,
  input  logic csr_wr,
  input  logic flag_wbit,
  output logic flag,
  output logic req
);
  logic armed;
  logic flag_clr;
  logic req_set;

  assign flag_clr = csr_wr && !flag_wbit && armed;
  assign req_set  = match && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
      req   <= 1'b0;
    end else begin
      if (match)         flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;

      if (flag_clr)            armed <= 1'b0;
      else if (csr_rd && flag) armed <= 1'b1;

      if (req_set)   req <= 1'b1;
      else if (done) req <= 1'b0;
    end
  end

  // R7: a hardware set beats a simultaneous software clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  // R7: no clear without a prior arming read
  a_r7_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag);
  // R8: enabled match raises the request
  a_r8_req_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    req_set |=> req);
  // R8: no request appears without an enabled match
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !req_set) |=> !req);
  // R9: request holds until serviced
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !done) |=> req);
  // R10: one done clears a pending request however many matches merged
  a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req && done && !req_set) |=> !req);
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
  import rft_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        refresh_done,
  output logic        refresh_req
);
  logic [SEL_W-1:0] sel_q;
  logic             en_q;
  logic [CNT_W-1:0] tc_q;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             match;
  logic             flag;
  logic             csr_wr, csr_rd, cnt_wr, tc_wr;
  logic [REG_W-1:0] rd_mux;

  assign csr_wr = bus_wr && (bus_addr == OFS_CSR);
  assign csr_rd = bus_rd && (bus_addr == OFS_CSR);
  assign cnt_wr = bus_wr && (bus_addr == OFS_CNT);
  assign tc_wr  = bus_wr && (bus_addr == OFS_TC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= 1'b0;
      tc_q  <= '0;
    end else begin
      if (csr_wr) begin
        sel_q <= bus_wdata[SEL_W-1:0];
        en_q  <= bus_wdata[CSR_EN_BIT];
      end
      if (tc_wr) tc_q <= bus_wdata[CNT_W-1:0];
    end
  end

  rft_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (sel_q),
    .tick (tick)
  );

  rft_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wr_cnt(cnt_wr),
    .wr_val(bus_wdata[CNT_W-1:0]),
    .tc_val(tc_q),
    .cnt   (cnt),
    .match (match)
  );

  rft_req_ctrl u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .match    (match),
    .en       (en_q),
    .done     (refresh_done),
    .csr_rd   (csr_rd),
    .csr_wr   (csr_wr),
    .flag_wbit(bus_wdata[CSR_FLAG_BIT]),
    .flag     (flag),
    .req      (refresh_req)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_CSR: begin
        rd_mux[SEL_W-1:0]    = sel_q;
        rd_mux[CSR_EN_BIT]   = en_q;
        rd_mux[CSR_FLAG_BIT] = flag;
      end
      OFS_CNT: rd_mux[CNT_W-1:0] = cnt;
      OFS_TC:  rd_mux[CNT_W-1:0] = tc_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  // R6: upper byte of every read is zero
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rdata[15:8] == 8'h00);
  // R11: read data is zero outside the cycle after a read strobe
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 16'h0000);
endmodule

// File: tb/rfsh_interval_timer_tb.sv
module rfsh_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        refresh_done = 1'b0;
  logic        refresh_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  rfsh_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .refresh_done(refresh_done), .refresh_req(refresh_req)
  );

  // addr, write data, expected read-back (counter stopped)
  localparam logic [33:0] VEC [0:5] = '{
    {2'd2, 16'h0012, 16'h0012},
    {2'd2, 16'hABCD, 16'h00CD},
    {2'd1, 16'h0005, 16'h0005},
    {2'd1, 16'hFF33, 16'h0033},
    {2'd0, 16'h0008, 16'h0088},
    {2'd3, 16'h1234, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk); refresh_done = 1'b1;
    @(negedge clk); refresh_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles between two request rises, servicing the first
  task automatic period(output int n);
    int w;
    w = 0;
    while (refresh_req !== 1'b1 && w < 20000) begin @(negedge clk); w++; end
    refresh_done = 1'b1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) refresh_done = 1'b0;
    end while (refresh_req !== 1'b1 && n < 20000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int p;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req after reset", {15'd0, refresh_req}, 16'h0000);
    chk("R1 rdata after reset", bus_rdata, 16'h0000);
    rd(2'd1, r); chk("R1 counter reset", r, 16'h0000);
    rd(2'd2, r); chk("R1 constant reset", r, 16'h0000);

    // R6 R11 register table
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][33:32], VEC[i][31:16]);
      rd(VEC[i][33:32], r);
      chk($sformatf("R6/R11 vector %0d", i), r, VEC[i][15:0]);
    end

    // R3: write during a match cycle wins
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h0009);
    rd(2'd1, r); chk("R3 write beats match clear", r, 16'h0009);
    // R4: match clears and flags
    wr(2'd2, 16'h0014);
    wr(2'd1, 16'h0014);
    rd(2'd1, r); chk("R4 counter cleared", r, 16'h0000);
    rd(2'd0, r); chk("R4 flag set", r, 16'h0080);

    // R7 flag protocol (previous read armed it)
    wr(2'd0, 16'h0000);
    rd(2'd0, r); chk("R7 flag cleared after read", r, 16'h0000);
    wr(2'd1, 16'h0014);
    wr(2'd0, 16'h0000);
    rd(2'd0, r); chk("R7 clear ignored without read", r, 16'h0080);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0000);
    rd(2'd0, r); chk("R7 set wins over clear", r, 16'h0080);

    // R2 R4 match period, /4 with constant 5
    wr(2'd2, 16'h0005); wr(2'd1, 16'h0000); done_pulse();
    chk("R9 request cleared by done", {15'd0, refresh_req}, 16'h0000);
    wr(2'd0, 16'h0009);
    period(p); chk("R2 period /4 c5", 16'(p), 16'd20);
    // /16 with constant 3
    wr(2'd0, 16'h0000); wr(2'd2, 16'h0003); wr(2'd1, 16'h0000); done_pulse();
    wr(2'd0, 16'h000A);
    period(p); chk("R2 period /16 c3", 16'(p), 16'd48);
    idle(10); chk("R9 request held without done", {15'd0, refresh_req}, 16'h0001);

    // R10: merged matches, one done drains
    idle(200);
    chk("R10 still one request", {15'd0, refresh_req}, 16'h0001);
    wr(2'd0, 16'h0000);
    done_pulse();
    chk("R10 single done clears", {15'd0, refresh_req}, 16'h0000);
    idle(20);
    chk("R10 nothing queued", {15'd0, refresh_req}, 16'h0000);

    // R8: disabled refresh gives flag but no request
    wr(2'd2, 16'h0005); wr(2'd1, 16'h0000);
    rd(2'd0, r); wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0001);
    idle(60);
    chk("R8 no request when disabled", {15'd0, refresh_req}, 16'h0000);
    rd(2'd0, r); chk("R8 flag set when disabled", r, 16'h0081);

    // R5: start above constant, must wrap before matching
    wr(2'd0, 16'h0000); wr(2'd2, 16'h000A); wr(2'd1, 16'h00FE); done_pulse();
    wr(2'd0, 16'h0009);
    idle(40);
    chk("R5 no early match", {15'd0, refresh_req}, 16'h0000);
    idle(20);
    chk("R5 match after wrap", {15'd0, refresh_req}, 16'h0001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule